// File: doc/BRIEF.md
# Per-Core Interrupt Status and Mailbox Register Bank

This block is the register bank that one processor core owns inside a multi-core inter-processor interrupt controller. Other agents post interrupt requests to the core by writing bit patterns to a write-to-set port. The core acknowledges those requests through a write-to-clear port. An enable register selects which pending bits may assert the interrupt line. Eight 32-bit mailbox words let a sender leave a small message for the core to read.

The interrupt output is a stored flag and not a live AND of status and enable. It is updated only when the set or clear port is written, and the conditions for the two are not symmetric. A set write raises the line when the new status has an enabled bit. A clear write lowers the line only when status becomes zero while enable is nonzero. A write to the enable register leaves the line as it is. All accesses are 32 bits wide and word aligned. The bank uses the low eight address bits and ignores the rest. Read data is registered, so it appears one cycle after the address.

Top module: `ipi_core_bank`

## Requirements
- R1: Only address bits [7:2] select a register. Bits [1:0] and every bit above bit 7 are ignored, so an address with high bits set reaches the same register as its low byte.
- R2: Status (offset 0x00) is read-only. A write to it leaves status unchanged, and `wr_err` is high for exactly the one cycle after that write.
- R3: A write to the set port (offset 0x08) ORs `wr_data` into status. After that write `irq` becomes 1 if the new status is nonzero and has a bit in common with enable. Otherwise `irq` keeps its value.
- R4: A write to the clear port (offset 0x0C) clears the status bits that are 1 in `wr_data`. After that write `irq` becomes 0 if the new status is zero and enable is nonzero. Otherwise `irq` keeps its value.
- R5: Reads of the set port and the clear port always return zero.
- R6: Eight mailbox words occupy offsets 0x20 to 0x3C. Word index = (offset − 0x20) >> 2. Each word reads back the last value written to it.
- R7: A write to the enable register (offset 0x04) replaces enable and never changes `irq` in the cycle that follows.
- R8: A read of an unmapped offset (0x10–0x1C, 0x40–0xFC) returns zero. A write to an unmapped offset changes no register and makes `wr_err` high for one cycle.
- R9: A synchronous active-high `rst` clears status, enable, all mailbox words, `irq`, `wr_err` and `rd_data`.
- R10: `rd_data` shows the register addressed in the previous cycle. If that cycle also wrote the same register, `rd_data` shows the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (12) | Word address; only bits [7:2] decoded |
| wr_en | input | 1 | Write strobe for the current address |
| wr_data | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Registered read data for the previous cycle's address |
| irq | output | 1 | Interrupt line to the core |
| wr_err | output | 1 | One-cycle flag after a write to status or an unmapped offset |

## Verification
The bench builds the bank with its defaults: a 12-bit address, 32-bit data and eight mailbox words. With a 12-bit address, the bench can set bits above bit 7 and show that they alias onto the same registers. With eight words, it can cover the whole mailbox window, up to the last word at 0x3C and the first unmapped word at 0x40. A 32-bit status leaves room for patterns where status and enable do not overlap. Those patterns separate the raise and lower conditions. The most important is a clear that empties status while enable is zero, which must leave the line high.

// File: rtl/ipi_bank_pkg.sv
package ipi_bank_pkg;
  typedef enum logic [2:0] {
    TGT_STATUS = 3'd0,
    TGT_ENABLE = 3'd1,
    TGT_SET    = 3'd2,
    TGT_CLEAR  = 3'd3,
    TGT_MBOX   = 3'd4,
    TGT_NONE   = 3'd5
  } ipi_tgt_e;

  localparam int DECODE_BITS = 8;
endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
  import ipi_bank_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int MBOX_WORDS = 8,
  parameter int MBOX_BASE  = 32,
  parameter int IDX_W      = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output ipi_tgt_e          tgt,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [8:0] WIN_LO = 9'(MBOX_BASE);
  localparam logic [8:0] WIN_HI = 9'(MBOX_BASE + 4 * MBOX_WORDS);

  logic [DECODE_BITS-1:0] off;
  logic [DECODE_BITS-1:0] rel;

  assign off = addr[DECODE_BITS-1:0];
  assign rel = off - WIN_LO[DECODE_BITS-1:0];
  assign idx = rel[2 +: IDX_W];

  always_comb begin
    if ({1'b0, off} >= WIN_LO && {1'b0, off} < WIN_HI) begin
      tgt = TGT_MBOX;
    end else begin
      case (off[DECODE_BITS-1:2])
        6'd0:    tgt = TGT_STATUS;
        6'd1:    tgt = TGT_ENABLE;
        6'd2:    tgt = TGT_SET;
        6'd3:    tgt = TGT_CLEAR;
        default: tgt = TGT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ipi_mbox_words.sv
module ipi_mbox_words #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] word_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        word_q[g] <= '0;
      end else if (we && idx == IDX_W'(g)) begin
        word_q[g] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= word_q[idx];
    end
  end
endmodule

// File: rtl/ipi_status_ctrl.sv
module ipi_status_ctrl #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic              en_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] enable,
  output logic              irq
);
  logic [DATA_W-1:0] st_after_set;
  logic [DATA_W-1:0] st_after_clr;
  logic              raise;
  logic              lower;

  assign st_after_set = status | wdata;
  assign st_after_clr = status & ~wdata;
  assign raise = set_we && (st_after_set != '0) && ((st_after_set & enable) != '0);
  assign lower = clr_we && (st_after_clr == '0) && (enable != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      enable <= '0;
      irq    <= 1'b0;
    end else begin
      if (set_we) begin
        status <= st_after_set;
      end else if (clr_we) begin
        status <= st_after_clr;
      end
      if (en_we) begin
        enable <= wdata;
      end
      if (raise) begin
        irq <= 1'b1;
      end else if (lower) begin
        irq <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ipi_core_bank.sv
module ipi_core_bank
  import ipi_bank_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int MBOX_WORDS = 8,
  parameter int MBOX_BASE  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic              wr_err
);
  localparam int IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1;

  ipi_tgt_e          tgt;
  ipi_tgt_e          sel_q;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] enable;
  logic [DATA_W-1:0] reg_q;
  logic [DATA_W-1:0] mb_rdata;

  ipi_addr_decode #(
    .ADDR_W(ADDR_W), .MBOX_WORDS(MBOX_WORDS), .MBOX_BASE(MBOX_BASE), .IDX_W(IDX_W)
  ) u_dec (
    .addr(addr), .tgt(tgt), .idx(idx)
  );

  ipi_status_ctrl #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst(rst),
    .set_we(wr_en && tgt == TGT_SET),
    .clr_we(wr_en && tgt == TGT_CLEAR),
    .en_we(wr_en && tgt == TGT_ENABLE),
    .wdata(wr_data),
    .status(status), .enable(enable), .irq(irq)
  );

  ipi_mbox_words #(.DATA_W(DATA_W), .DEPTH(MBOX_WORDS), .IDX_W(IDX_W)) u_mbox (
    .clk(clk), .rst(rst),
    .we(wr_en && tgt == TGT_MBOX),
    .idx(idx), .wdata(wr_data), .rdata(mb_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= TGT_NONE;
      reg_q  <= '0;
      wr_err <= 1'b0;
    end else begin
      sel_q  <= tgt;
      reg_q  <= (tgt == TGT_STATUS) ? status : enable;
      wr_err <= wr_en && (tgt == TGT_STATUS || tgt == TGT_NONE);
    end
  end

  always_comb begin
    case (sel_q)
      TGT_STATUS, TGT_ENABLE: rd_data = reg_q;
      TGT_MBOX:               rd_data = mb_rdata;
      default:                rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ipi_core_bank_chk.sv
module ipi_core_bank_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq,
  input logic              wr_err
);
  logic [7:0] lo;
  assign lo = addr[7:0];

  // R3
  irq_rise_only_on_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(irq)) |-> $past(wr_en && lo[7:2] == 6'd2));

  // R4
  irq_fall_only_on_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(irq)) |-> $past(wr_en && lo[7:2] == 6'd3));

  // R5
  setclr_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lo[7:2] == 6'd2 || lo[7:2] == 6'd3)) |-> (rd_data == '0));

  // R7
  enable_keeps_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en && lo[7:2] == 6'd1)) |-> $stable(irq));

  // R2
  status_write_err_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en && lo[7:2] == 6'd0)) |-> wr_err);

  // R8
  err_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> $past(wr_en));
endmodule

bind ipi_core_bank ipi_core_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
  .rd_data(rd_data), .irq(irq), .wr_err(wr_err)
);

// File: tb/sim_ipi_core_bank.sv
module sim_ipi_core_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;
  logic        wr_err;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_st, m_en;
  logic [31:0] m_mb [8];
  logic        m_irq;
  logic [31:0] e_rd;
  logic        e_err;

  always #10 clk = ~clk;

  ipi_core_bank u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq), .wr_err(wr_err)
  );

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic string rd_tag(input logic [7:0] off);
    if (off[7:2] == 6'd0) return "R2";
    if (off[7:2] == 6'd1) return "R7";
    if (off[7:2] == 6'd2 || off[7:2] == 6'd3) return "R5";
    if (off >= 8'h20 && off < 8'h40) return "R6";
    return "R8";
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    m_st = '0; m_en = '0; m_irq = 1'b0; e_rd = '0; e_err = 1'b0;
    for (int i = 0; i < 8; i++) m_mb[i] = '0;
  endtask

  task automatic step(input logic [11:0] a, input logic we, input logic [31:0] d, input string tag);
    logic [7:0] off;
    logic       mb;
    int         ix;
    @(negedge clk);
    addr = a; wr_en = we; wr_data = d;
    @(posedge clk);
    off = a[7:0];
    mb = (off >= 8'h20) && (off < 8'h40);
    ix = (int'(off) - 32) / 4;
    if (off[7:2] == 6'd0) e_rd = m_st;
    else if (off[7:2] == 6'd1) e_rd = m_en;
    else if (mb) e_rd = m_mb[ix];
    else e_rd = '0;
    e_err = we && !mb && !(off[7:2] == 6'd1 || off[7:2] == 6'd2 || off[7:2] == 6'd3);
    if (we) begin
      if (mb) m_mb[ix] = d;
      else if (off[7:2] == 6'd1) m_en = d;
      else if (off[7:2] == 6'd2) begin
        m_st = m_st | d;
        if (m_st != 0 && (m_st & m_en) != 0) m_irq = 1'b1;
      end else if (off[7:2] == 6'd3) begin
        m_st = m_st & ~d;
        if (m_st == 0 && m_en != 0) m_irq = 1'b0;
      end
    end
    #5;
    chk(rd_tag(off), "rd_data", rd_data, e_rd);
    chk(tag, "irq", {31'd0, irq}, {31'd0, m_irq});
    chk((off[7:2] == 6'd0) ? "R2" : "R8", "wr_err", {31'd0, wr_err}, {31'd0, e_err});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; addr = 12'h020; wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
    @(posedge clk); @(posedge clk);
    model_clear();
    #5;
    chk("R9", "rd_data", rd_data, 32'd0);
    chk("R9", "irq", {31'd0, irq}, 32'd0);
    chk("R9", "wr_err", {31'd0, wr_err}, 32'd0);
    @(negedge clk);
    rst = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    model_clear();
    do_reset();
    // R9: every register reads zero after reset
    step(12'h000, 0, 0, "R9");
    step(12'h004, 0, 0, "R9");
    for (int i = 0; i < 8; i++) step(12'h020 + 12'(4 * i), 0, 0, "R9");

    // R3: set with enable zero does not raise
    step(12'h008, 1, 32'h0000_0005, "R3");
    step(12'h000, 0, 0, "R3");
    // R7: enabling an already pending bit leaves irq low
    step(12'h004, 1, 32'h0000_0004, "R7");
    step(12'h004, 0, 0, "R7");
    // R3: set write now raises
    step(12'h008, 1, 32'h0000_0100, "R3");
    step(12'h008, 0, 0, "R5");
    step(12'h00C, 0, 0, "R5");
    // R4: partial clear keeps irq high
    step(12'h00C, 1, 32'h0000_0001, "R4");
    step(12'h000, 0, 0, "R4");
    // R7: disabling does not lower irq
    step(12'h004, 1, 32'h0000_0000, "R7");
    // R4: clear to zero with enable zero keeps irq high
    step(12'h00C, 1, 32'hFFFF_FFFF, "R4");
    step(12'h000, 0, 0, "R4");
    // R4: clear to zero with enable nonzero lowers irq
    step(12'h004, 1, 32'h8000_0000, "R7");
    step(12'h00C, 1, 32'h0000_0000, "R4");
    // R3: set of disabled bit only, no raise
    step(12'h008, 1, 32'h0000_0002, "R3");
    step(12'h008, 1, 32'h8000_0000, "R3");
    // R4: clear leaving status nonzero keeps irq
    step(12'h00C, 1, 32'h8000_0000, "R4");
    step(12'h00C, 1, 32'h0000_0002, "R4");

    // R2: status write ignored, error flagged
    step(12'h008, 1, 32'h0000_0030, "R3");
    step(12'h000, 1, 32'hFFFF_FFFF, "R2");
    step(12'h000, 0, 0, "R2");

    // R6: mailbox words, R10 read-before-write on same address
    for (int i = 0; i < 8; i++) step(12'h020 + 12'(4 * i), 1, 32'hA5A5_0000 + 32'(i * 17), "R6");
    for (int i = 0; i < 8; i++) step(12'h020 + 12'(4 * i), 0, 0, "R6");
    step(12'h03C, 1, 32'h1234_5678, "R10");
    step(12'h03C, 0, 0, "R10");

    // R1: high address bits and low two bits ignored
    step(12'hF24, 1, 32'hDEAD_BEEF, "R1");
    step(12'h027, 0, 0, "R1");
    step(12'h904, 0, 0, "R1");
    step(12'h30A, 1, 32'h0000_0001, "R1");

    // R8: unmapped offsets
    step(12'h010, 0, 0, "R8");
    step(12'h01C, 1, 32'hFFFF_FFFF, "R8");
    step(12'h040, 1, 32'hFFFF_FFFF, "R8");
    step(12'h0FC, 1, 32'hFFFF_FFFF, "R8");
    step(12'h0FC, 0, 0, "R8");
    step(12'h000, 0, 0, "R8");
    step(12'h004, 0, 0, "R8");
    for (int i = 0; i < 8; i++) step(12'h020 + 12'(4 * i), 0, 0, "R8");

    // R9: mid-run reset clears everything
    do_reset();
    step(12'h000, 0, 0, "R9");
    step(12'h004, 0, 0, "R9");
    for (int i = 0; i < 8; i++) step(12'h020 + 12'(4 * i), 0, 0, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule